// File: doc/BRIEF.md
# Vectored Interrupt Controller (64 sources)

This block gathers 64 interrupt request lines and presents one interrupt line to a processor, together with a vector register that names the source to service. Every source has its own configuration word that selects edge or level sensitivity and gives it a priority level. Each source also has an enable bit. Software sets enable bits through set words and clears them through separate clear words. Each of these words covers half of the sources. Among the sources that are enabled and pending, the one with the highest priority wins. When two winners share a level, the lower index wins.

Software reaches the block through a single-cycle register port. A write takes effect at the clock edge on which `reg_we_i` is high. Read data is combinational from the registered state. The control word holds a global enable and a self-clearing soft reset. A write of any value to the end-of-interrupt word acknowledges the current request. A latched edge request is cleared by writing the source's configuration word with the edge bit flipped and then writing the original value back.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A write to offset 0x000 (low, sources 0–31) or 0x008 (high, sources 32–63) sets the enable of every source whose bit is 1. Bit n maps to source n, or n+32 in the high word. Reading either offset returns the current enable mask of that half.
- R2: A write to offset 0x010 (low) or 0x018 (high) clears the enable of every source whose bit is 1, and zero bits leave enables unchanged. Reading these offsets returns the same enable half.
- R3: Source n has a configuration word at 0x200 + 8·n. Bit 31 selects edge mode and bits [2:0] hold the priority. All other bits read back as zero.
- R4: A level-mode source is pending whenever its input is high. The vector read at 0x020 follows the input in the same cycle.
- R5: An edge-mode source latches pending on a rising input and holds it after the input falls. A configuration write that changes its edge bit clears the latch. A write that leaves the edge bit unchanged does not clear it.
- R6: The vector read at 0x020 returns the index of the enabled pending source with the highest priority, with ties going to the lowest index. It returns 64 when no enabled source is pending.
- R7: `irq_o` goes high one cycle after the global enable (bit 0 of 0x030) is set while at least one enabled source is pending. It stays low whenever the global enable is clear.
- R8: A write of any value to offset 0x028 forces `irq_o` low in the following cycle. The output is then re-evaluated on the cycle after that.
- R9: Writing 1 to bit 1 of offset 0x030 returns every enable, configuration word, edge latch, the global enable and `irq_o` to zero.
- R10: Reads from undefined offsets return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 64 | Raw interrupt request lines |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 10 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
On every cycle, the assertions check the following:
- the gating of `irq_o` by the global enable;
- the one-cycle drop after an end-of-interrupt write;
- that the output rises whenever something enabled is pending;
- that the vector is either out of range or names an enabled pending source;
- the clearing effect of a soft reset and of a write to the low clear word.

Other behaviours can only be shown by the bench's scenarios:
- the arbitration order under mixed priorities;
- the full enable and configuration readback;
- edge latching and the rewrite that clears it;
- the silence of undefined offsets.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam int unsigned OFS_ENA_LO   = 'h000;
    localparam int unsigned OFS_ENA_HI   = 'h008;
    localparam int unsigned OFS_DIS_LO   = 'h010;
    localparam int unsigned OFS_DIS_HI   = 'h018;
    localparam int unsigned OFS_VECTOR   = 'h020;
    localparam int unsigned OFS_EOI      = 'h028;
    localparam int unsigned OFS_CTRL     = 'h030;
    localparam int unsigned OFS_CFG_BASE = 'h200;

    localparam int unsigned CTRL_GENA_BIT  = 0;
    localparam int unsigned CTRL_SRST_BIT  = 1;
    localparam int unsigned CFG_EDGE_BIT   = 31;
endpackage

// File: rtl/ivc_edge_bank.sv
module ivc_edge_bank #(
    parameter int NSRC = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] edge_mode_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] latch_o
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic prev_q;
        logic latch_d, latch_q;

        always_comb begin
            latch_d = latch_q;
            if (clr_i[g] || !edge_mode_i[g]) begin
                latch_d = 1'b0;
            end else if (src_i[g] && !prev_q) begin
                latch_d = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q  <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                prev_q  <= src_i[g];
                latch_q <= latch_d;
            end
        end

        assign latch_o[g] = latch_q;
    end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter #(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 3,
    localparam int VEC_W = $clog2(NSRC + 1)
) (
    input  logic [NSRC-1:0]        req_i,
    input  logic [NSRC*PRIO_W-1:0] prio_i,
    output logic [VEC_W-1:0]       vec_o,
    output logic                   any_o
);
    logic              found;
    logic [PRIO_W-1:0] best;
    logic [VEC_W-1:0]  pick;

    // Scan from the top index down; ">=" lets a lower index take a tie.
    always_comb begin
        found = 1'b0;
        best  = '0;
        pick  = VEC_W'(NSRC);
        for (int n = NSRC - 1; n >= 0; n--) begin
            if (req_i[n] && (!found || prio_i[n*PRIO_W +: PRIO_W] >= best)) begin
                found = 1'b1;
                best  = prio_i[n*PRIO_W +: PRIO_W];
                pick  = VEC_W'(n);
            end
        end
        vec_o = pick;
        any_o = found;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_src_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);
    localparam int HALF  = NSRC / 2;
    localparam int IDX_W = $clog2(NSRC);
    localparam int VEC_W = $clog2(NSRC + 1);

    typedef struct packed {
        logic [NSRC-1:0]        ena;
        logic [NSRC-1:0]        edge_sel;
        logic [NSRC*PRIO_W-1:0] prio;
        logic                   gena;
        logic                   irq;
    } state_t;

    state_t s_d, s_q;

    // Address decode
    logic              wr_ena_lo, wr_ena_hi, wr_dis_lo, wr_dis_hi;
    logic              wr_eoi, wr_ctrl, wr_sreset, wr_cfg;
    logic              cfg_hit;
    logic [ADDR_W-1:0] cfg_off;
    logic [IDX_W-1:0]  cfg_idx;

    always_comb begin
        cfg_off = reg_addr_i - ADDR_W'(OFS_CFG_BASE);
        cfg_idx = cfg_off[IDX_W+2:3];
        cfg_hit = (reg_addr_i >= ADDR_W'(OFS_CFG_BASE)) && (cfg_off[2:0] == 3'b000)
                  && (32'(cfg_off[ADDR_W-1:3]) < NSRC);
        wr_ena_lo = reg_we_i && (reg_addr_i == ADDR_W'(OFS_ENA_LO));
        wr_ena_hi = reg_we_i && (reg_addr_i == ADDR_W'(OFS_ENA_HI));
        wr_dis_lo = reg_we_i && (reg_addr_i == ADDR_W'(OFS_DIS_LO));
        wr_dis_hi = reg_we_i && (reg_addr_i == ADDR_W'(OFS_DIS_HI));
        wr_eoi    = reg_we_i && (reg_addr_i == ADDR_W'(OFS_EOI));
        wr_ctrl   = reg_we_i && (reg_addr_i == ADDR_W'(OFS_CTRL));
        wr_sreset = wr_ctrl && reg_wdata_i[CTRL_SRST_BIT];
        wr_cfg    = reg_we_i && cfg_hit;
    end

    // Pending sources
    logic [NSRC-1:0]  latch, pend_raw, pend_m, edge_clr;
    logic [VEC_W-1:0] vec;
    logic             any_pend;

    always_comb begin
        edge_clr = '0;
        if (wr_sreset) begin
            edge_clr = '1;
        end else if (wr_cfg && (reg_wdata_i[CFG_EDGE_BIT] != s_q.edge_sel[cfg_idx])) begin
            edge_clr[cfg_idx] = 1'b1;
        end
    end

    ivc_edge_bank #(.NSRC(NSRC)) u_edges (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (irq_src_i),
        .edge_mode_i (s_q.edge_sel),
        .clr_i       (edge_clr),
        .latch_o     (latch)
    );

    always_comb begin
        for (int n = 0; n < NSRC; n++) begin
            pend_raw[n] = s_q.edge_sel[n] ? latch[n] : irq_src_i[n];
        end
        pend_m = pend_raw & s_q.ena;
    end

    ivc_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
        .req_i  (pend_m),
        .prio_i (s_q.prio),
        .vec_o  (vec),
        .any_o  (any_pend)
    );

    // Next state
    always_comb begin
        s_d = s_q;
        if (wr_sreset) begin
            s_d = '0;
        end else begin
            if (wr_ena_lo) s_d.ena[0 +: HALF]    = s_q.ena[0 +: HALF] | reg_wdata_i[HALF-1:0];
            if (wr_ena_hi) s_d.ena[HALF +: HALF] = s_q.ena[HALF +: HALF] | reg_wdata_i[HALF-1:0];
            if (wr_dis_lo) s_d.ena[0 +: HALF]    = s_q.ena[0 +: HALF] & ~reg_wdata_i[HALF-1:0];
            if (wr_dis_hi) s_d.ena[HALF +: HALF] = s_q.ena[HALF +: HALF] & ~reg_wdata_i[HALF-1:0];
            if (wr_cfg) begin
                s_d.edge_sel[cfg_idx]               = reg_wdata_i[CFG_EDGE_BIT];
                s_d.prio[cfg_idx*PRIO_W +: PRIO_W]  = reg_wdata_i[PRIO_W-1:0];
            end
            if (wr_ctrl) s_d.gena = reg_wdata_i[CTRL_GENA_BIT];
            s_d.irq = s_q.gena && any_pend && !wr_eoi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Read mux
    always_comb begin
        reg_rdata_o = '0;
        if (cfg_hit) begin
            reg_rdata_o[CFG_EDGE_BIT] = s_q.edge_sel[cfg_idx];
            reg_rdata_o[PRIO_W-1:0]   = s_q.prio[cfg_idx*PRIO_W +: PRIO_W];
        end else if (reg_addr_i == ADDR_W'(OFS_ENA_LO) || reg_addr_i == ADDR_W'(OFS_DIS_LO)) begin
            reg_rdata_o[HALF-1:0] = s_q.ena[0 +: HALF];
        end else if (reg_addr_i == ADDR_W'(OFS_ENA_HI) || reg_addr_i == ADDR_W'(OFS_DIS_HI)) begin
            reg_rdata_o[HALF-1:0] = s_q.ena[HALF +: HALF];
        end else if (reg_addr_i == ADDR_W'(OFS_VECTOR)) begin
            reg_rdata_o[VEC_W-1:0] = vec;
        end else if (reg_addr_i == ADDR_W'(OFS_CTRL)) begin
            reg_rdata_o[CTRL_GENA_BIT] = s_q.gena;
        end
    end

    assign irq_o = s_q.irq;
endmodule

module ivc_checker #(
    parameter int NSRC = 64,
    localparam int IDX_W = $clog2(NSRC),
    localparam int VEC_W = $clog2(NSRC + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             gena_q,
    input logic [NSRC-1:0]  ena_q,
    input logic [NSRC-1:0]  pend_m,
    input logic [VEC_W-1:0] vec,
    input logic             any_pend,
    input logic             eoi_wr,
    input logic             sreset,
    input logic             dis_lo_wr,
    input logic             wdata0
);
    // R7
    gena_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gena_q |=> !irq_o);

    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gena_q && any_pend && !eoi_wr && !sreset) |=> irq_o);

    // R8
    eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_wr |=> !irq_o);

    // R6
    vec_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(vec) >= NSRC) == !any_pend);

    // R6
    vec_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(vec) < NSRC) |-> pend_m[vec[IDX_W-1:0]]);

    // R9
    sreset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sreset |=> (ena_q == '0 && !gena_q && !irq_o));

    // R2
    dis_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_lo_wr && wdata0) |=> !ena_q[0]);
endmodule

bind irq_vector_ctrl ivc_checker #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .gena_q    (s_q.gena),
    .ena_q     (s_q.ena),
    .pend_m    (pend_m),
    .vec       (vec),
    .any_pend  (any_pend),
    .eoi_wr    (wr_eoi),
    .sreset    (wr_sreset),
    .dis_lo_wr (wr_dis_lo),
    .wdata0    (reg_wdata_i[0])
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        we = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          prio_m [64];
    logic [63:0] ena_b;

    always #5 clk = ~clk;

    irq_vector_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_src_i   (src),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        addr = 10'(a); wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        addr = 10'(a);
        #1;
        d = rdata;
    endtask

    function automatic int exp_vec(logic [63:0] p);
        int best = -1;
        int idx = 64;
        for (int n = 0; n < 64; n++) begin
            if (p[n] && prio_m[n] > best) begin
                best = prio_m[n];
                idx = n;
            end
        end
        return idx;
    endfunction

    function automatic int cfg_addr(int n);
        return 'h200 + 8 * n;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] lfsr;
        for (int n = 0; n < 64; n++) prio_m[n] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd('h000, d); chk("R1 reset ena lo", d, 0);
        rd('h008, d); chk("R1 reset ena hi", d, 0);
        rd('h020, d); chk("R6 reset vector", d, 64);
        chk("R7 reset irq", irq, 0);

        // R1 / R2 enable set and clear
        wr('h000, 32'hA5A5_0F0F); rd('h000, d); chk("R1 set lo", d, 32'hA5A5_0F0F);
        wr('h008, 32'h0000_FFFF); rd('h008, d); chk("R1 set hi", d, 32'h0000_FFFF);
        wr('h000, 32'h0000_0030); rd('h000, d); chk("R1 set is OR", d, 32'hA5A5_0F3F);
        wr('h010, 32'h0000_000F); rd('h000, d); chk("R2 clear lo", d, 32'hA5A5_0F30);
        rd('h010, d); chk("R2 clear lo readback", d, 32'hA5A5_0F30);
        wr('h018, 32'h0); rd('h008, d); chk("R2 zero bits no effect", d, 32'h0000_FFFF);
        wr('h018, 32'h0000_0F00); rd('h018, d); chk("R2 clear hi", d, 32'h0000_F0FF);

        // R10 undefined offsets
        wr('h040, 32'hFFFF_FFFF); rd('h040, d); chk("R10 undef read", d, 0);
        wr('h004, 32'hFFFF_FFFF); rd('h004, d); chk("R10 unaligned read", d, 0);
        rd('h000, d); chk("R10 ena lo untouched", d, 32'hA5A5_0F30);
        rd('h030, d); chk("R10 ctrl untouched", d, 0);

        // R3 configuration readback sweep
        for (int n = 0; n < 64; n++) begin
            wr(cfg_addr(n), 32'h0000_FF00 | 32'(n % 8));
            prio_m[n] = n % 8;
        end
        for (int n = 0; n < 64; n++) begin
            rd(cfg_addr(n), d); chk("R3 cfg readback", d, 32'(n % 8));
        end

        // R4 / R7 single level source sweep, all enabled
        wr('h000, 32'hFFFF_FFFF); wr('h008, 32'hFFFF_FFFF); wr('h030, 32'h1);
        ena_b = '1;
        for (int n = 0; n < 64; n++) begin
            src = 64'd1 << n;
            rd('h020, d); chk("R4 level vector", d, 32'(n));
            chk("R7 irq registered", irq, 0);
            @(negedge clk);
            chk("R7 irq raised", irq, 1);
            src = '0;
            rd('h020, d); chk("R4 level drop", d, 64);
            @(negedge clk);
        end

        // R6 arbitration patterns
        src = '1; rd('h020, d); chk("R6 all pending tie", d, 7);
        lfsr = 64'hACE1_2468_1357_BDF0;
        for (int k = 0; k < 24; k++) begin
            if (k == 12) begin
                wr('h010, 32'h5555_5555); wr('h018, 32'h0F0F_0F0F);
                ena_b = ena_b & ~{32'h0F0F_0F0F, 32'h5555_5555};
            end
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            src = lfsr & {lfsr[31:0], lfsr[63:32]};
            rd('h020, d); chk("R6 pattern vector", d, 32'(exp_vec(src & ena_b)));
        end
        src = '0;
        wr('h000, 32'hFFFF_FFFF); wr('h008, 32'hFFFF_FFFF);

        // R7 global enable gating
        src = 64'd1 << 3;
        wr('h030, 32'h0);
        @(negedge clk);
        chk("R7 gena off irq low", irq, 0);
        rd('h020, d); chk("R6 vector with gena off", d, 3);
        wr('h030, 32'h1);
        chk("R7 one cycle after gena", irq, 0);
        @(negedge clk);
        chk("R7 gena on irq high", irq, 1);

        // R8 end of interrupt
        wr('h028, 32'hDEAD_BEEF);
        chk("R8 eoi drop", irq, 0);
        @(negedge clk);
        chk("R8 eoi re-evaluate", irq, 1);
        src = '0;
        @(negedge clk);

        // R5 edge latching and clear by rewrite
        wr(cfg_addr(9), 32'h8000_0002); prio_m[9] = 2;
        rd('h020, d); chk("R5 edge idle", d, 64);
        src[9] = 1'b1; @(negedge clk); src[9] = 1'b0;
        rd('h020, d); chk("R5 edge latched", d, 9);
        @(negedge clk); @(negedge clk);
        rd('h020, d); chk("R5 edge held", d, 9);
        wr(cfg_addr(9), 32'h8000_0002);
        rd('h020, d); chk("R5 same edge bit keeps latch", d, 9);
        wr(cfg_addr(9), 32'h0000_0002);
        wr(cfg_addr(9), 32'h8000_0002);
        rd('h020, d); chk("R5 rewrite clears", d, 64);
        src[9] = 1'b1; @(negedge clk);
        rd('h020, d); chk("R5 relatch", d, 9);
        src[9] = 1'b0;

        // R9 soft reset
        src = 64'd1 << 3;
        wr('h030, 32'h2);
        rd('h000, d); chk("R9 ena lo cleared", d, 0);
        rd('h008, d); chk("R9 ena hi cleared", d, 0);
        rd('h030, d); chk("R9 gena cleared", d, 0);
        rd(cfg_addr(9), d); chk("R9 cfg cleared", d, 0);
        rd('h020, d); chk("R9 vector none", d, 64);
        chk("R9 irq low", irq, 0);
        src = '0;
        wr('h000, 32'h0000_0200); wr('h030, 32'h1);
        @(negedge clk);
        rd('h020, d); chk("R9 edge latch cleared", d, 64);
        chk("R9 irq stays low", irq, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule